// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

The block is a fully programmable two-level logic array with three primary inputs, five product terms and four outputs. Both the AND plane and the OR plane are held as bit matrices in configuration registers. Each product term chooses, for every input, whether to use the true literal, the complemented literal, both, or neither. Each output chooses any subset of the five terms and ORs them. Because the OR plane is a full matrix, one term can feed several outputs in the same pattern.

The pattern is loaded serially. While `cfg_shift` is high, one bit enters the shift chain on every rising clock edge, and the bit leaving the chain appears on `cfg_so`. The active pattern that drives the logic is a separate register. It is updated only when a shift burst ends, so the outputs keep the old function during a load. Outside of that one register, `dout` is a purely combinational function of `din`.

A two-state controller sequences the load. `CFG_IDLE` moves to `CFG_SHIFT` when `cfg_shift` is sampled high, and stays there while it remains high (transition SHIFT_HOLD). `CFG_SHIFT` returns to `CFG_IDLE` on the first edge at which `cfg_shift` is sampled low (transition COMMIT), and that edge copies the chain into the active pattern. `CFG_IDLE` stays in place while `cfg_shift` is low (transition IDLE_HOLD).

Top module: `pla_sop_array`

## Requirements
- R1: Input A is `din[2]`, B is `din[1]` and C is `din[0]`. Product term t is the AND of every literal whose connection bit is set: the true-literal bit of input j (A=0, B=1, C=2) is pattern bit 49-6t-2j and the complement bit is pattern bit 48-6t-2j.
- R2: A term with both the true and the complement bit of the same input set is 0 for every input value.
- R3: A term with none of its six connection bits set is 1.
- R4: Output k (`dout[k]`) is the OR of every term t whose OR bit, pattern bit 19-5k-t, is set, and a single term may drive several outputs at once.
- R5: An output with none of its five OR bits set drives 0.
- R6: On each rising edge with `cfg_shift` high, the chain shifts toward its top and `cfg_si` enters bit 0, so a 50-bit stream sent most significant bit first ends with its first bit at bit 49.
- R7: `cfg_so` shows chain bit 49, which is the bit shifted in 50 edges earlier, and it does not change on edges with `cfg_shift` low.
- R8: While `cfg_shift` is high the outputs follow the previous pattern. At the first edge with `cfg_shift` low the chain becomes the active pattern, and the outputs follow it from that cycle onward.
- R9: With `rst_n` low at a rising edge, the chain and the active pattern clear, so `dout` and `cfg_so` read 0.
- R10: Loading terms AB, B'C, AC', B'C', A gives F0 = A + B'C', F1 = AC' + AB, F2 = B'C' + AB and F3 = B'C + A on `dout[0]` to `dout[3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_shift | input | 1 | Shift enable for the configuration chain |
| cfg_si | input | 1 | Serial configuration data in |
| cfg_so | output | 1 | Bit leaving the configuration chain |
| din | input | 3 | Primary inputs A, B, C on bits 2, 1, 0 |
| dout | output | 4 | Logic outputs F0 to F3 |

## Verification
The case that is hardest to reach from the ports is a load that starts while a different pattern is active. In that case the outputs must keep the old function through 50 shift edges and switch exactly at the commit edge, while `cfg_so` replays the old stream. The bench therefore loads patterns back to back and keeps changing `din` during each burst. Its reference model compares `dout` and `cfg_so` every cycle, and directed loads cover contradictory terms, empty terms and empty OR rows.

// File: rtl/pla_pkg.sv
package pla_pkg;

    typedef enum logic [0:0] {
        CFG_IDLE  = 1'b0,
        CFG_SHIFT = 1'b1
    } cfg_state_e;

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain
    import pla_pkg::*;
#(
    parameter int CFG_W = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_shift,
    input  logic             cfg_si,
    output logic [CFG_W-1:0] chain_q,
    output logic [CFG_W-1:0] pattern_q
);

    cfg_state_e state_q;
    cfg_state_e state_d;
    logic       commit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CFG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and commit strobe
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            CFG_IDLE: begin
                if (cfg_shift) begin
                    state_d = CFG_SHIFT;
                end
            end
            CFG_SHIFT: begin
                if (!cfg_shift) begin
                    state_d = CFG_IDLE;
                    commit  = 1'b1;
                end
            end
            default: state_d = CFG_IDLE;
        endcase
    end

    // serial chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (cfg_shift) begin
            chain_q <= {chain_q[CFG_W-2:0], cfg_si};
        end
    end

    // active pattern, updated once per burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pattern_q <= '0;
        end else if (commit) begin
            pattern_q <= chain_q;
        end
    end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 5
) (
    input  logic [N_IN-1:0]          lit_in,
    input  logic [N_TERM*2*N_IN-1:0] and_bits,
    output logic [N_TERM-1:0]        term
);

    localparam int WORD_W = 2 * N_IN;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [WORD_W-1:0] word;
        logic [N_IN-1:0]   kill;

        assign word = and_bits[(N_TERM-t)*WORD_W-1 -: WORD_W];

        for (genvar j = 0; j < N_IN; j++) begin : g_lit
            logic x;
            assign x       = lit_in[N_IN-1-j];
            assign kill[j] = (word[WORD_W-1-2*j] & ~x) | (word[WORD_W-2-2*j] & x);
        end

        assign term[t] = ~|kill;
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_TERM = 5,
    parameter int N_OUT  = 4
) (
    input  logic [N_TERM-1:0]       term,
    input  logic [N_OUT*N_TERM-1:0] or_bits,
    output logic [N_OUT-1:0]        dout
);

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        logic [N_TERM-1:0] word;
        logic              hit;

        assign word = or_bits[(N_OUT-k)*N_TERM-1 -: N_TERM];

        always_comb begin
            hit = 1'b0;
            for (int t = 0; t < N_TERM; t++) begin
                hit = hit | (word[N_TERM-1-t] & term[t]);
            end
        end

        assign dout[k] = hit;
    end

endmodule

// File: rtl/pla_sop_array.sv
module pla_sop_array #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 5,
    parameter int N_OUT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_shift,
    input  logic             cfg_si,
    output logic             cfg_so,
    input  logic [N_IN-1:0]  din,
    output logic [N_OUT-1:0] dout
);

    localparam int AND_W = N_TERM * 2 * N_IN;
    localparam int OR_W  = N_OUT * N_TERM;
    localparam int CFG_W = AND_W + OR_W;

    logic [CFG_W-1:0]  cfg_chain;
    logic [CFG_W-1:0]  cfg_pattern;
    logic [N_TERM-1:0] term;

    pla_cfg_chain #(
        .CFG_W(CFG_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_shift(cfg_shift),
        .cfg_si   (cfg_si),
        .chain_q  (cfg_chain),
        .pattern_q(cfg_pattern)
    );

    assign cfg_so = cfg_chain[CFG_W-1];

    pla_and_plane #(
        .N_IN  (N_IN),
        .N_TERM(N_TERM)
    ) u_and (
        .lit_in  (din),
        .and_bits(cfg_pattern[CFG_W-1:OR_W]),
        .term    (term)
    );

    pla_or_plane #(
        .N_TERM(N_TERM),
        .N_OUT (N_OUT)
    ) u_or (
        .term   (term),
        .or_bits(cfg_pattern[OR_W-1:0]),
        .dout   (dout)
    );

endmodule

// File: rtl/pla_sop_array_chk.sv
module pla_sop_array_chk #(
    parameter int CFG_W = 50,
    parameter int OR_W  = 20,
    parameter int N_OUT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_shift,
    input logic             cfg_si,
    input logic             cfg_so,
    input logic [N_OUT-1:0] dout,
    input logic [CFG_W-1:0] chain,
    input logic [CFG_W-1:0] pattern
);

    AST_HOLD_WHILE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_shift) |-> $stable(pattern)); // R8

    AST_COMMIT_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_shift, 2) && !$past(cfg_shift)) |-> (pattern == $past(chain))); // R8

    AST_SO_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_shift) |-> $stable(cfg_so)); // R7

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_shift) |-> (chain[0] == $past(cfg_si))); // R6

    AST_EMPTY_OR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern[OR_W-1:0] == '0) |-> (dout == '0)); // R5

endmodule

bind pla_sop_array pla_sop_array_chk #(
    .CFG_W(CFG_W),
    .OR_W (OR_W),
    .N_OUT(N_OUT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_shift(cfg_shift),
    .cfg_si   (cfg_si),
    .cfg_so   (cfg_so),
    .dout     (dout),
    .chain    (cfg_chain),
    .pattern  (cfg_pattern)
);

// File: tb/tb_pla_sop_array.sv
module tb_pla_sop_array;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_shift = 1'b0;
    logic       cfg_si = 1'b0;
    logic       cfg_so;
    logic [2:0] din = 3'b000;
    logic [3:0] dout;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R9";
    bit    started = 0;
    bit    done = 0;

    // behavioural model state
    bit    m_chain[$];
    bit    m_act[50];
    bit    m_shifting = 0;

    logic [49:0] cfg_img;

    always #10 clk = ~clk;

    pla_sop_array dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_shift(cfg_shift),
        .cfg_si   (cfg_si),
        .cfg_so   (cfg_so),
        .din      (din),
        .dout     (dout)
    );

    // m_chain[0] is the chain top (bit 49)
    initial begin
        for (int i = 0; i < 50; i++) m_chain.push_back(1'b0);
    end

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            for (int i = 0; i < 50; i++) begin
                m_chain[i] = 1'b0;
                m_act[i] = 1'b0;
            end
            m_shifting = 0;
        end else begin
            if (m_shifting && !cfg_shift) begin
                for (int i = 0; i < 50; i++) m_act[i] = m_chain[i];
            end
            if (cfg_shift) begin
                void'(m_chain.pop_front());
                m_chain.push_back(cfg_si);
            end
            m_shifting = cfg_shift;
        end
    end

    // m_act[i] holds pattern bit 49-i
    function automatic bit pbit(int b);
        return m_act[49-b];
    endfunction

    function automatic logic [3:0] model_eval(logic [2:0] x);
        bit terms[5];
        logic [3:0] r;
        for (int t = 0; t < 5; t++) begin
            terms[t] = 1;
            for (int j = 0; j < 3; j++) begin
                bit v;
                v = x[2-j];
                if (pbit(49-6*t-2*j) && !v) terms[t] = 0;
                if (pbit(48-6*t-2*j) && v) terms[t] = 0;
            end
        end
        for (int k = 0; k < 4; k++) begin
            r[k] = 1'b0;
            for (int t = 0; t < 5; t++) begin
                if (pbit(19-5*k-t) && terms[t]) r[k] = 1'b1;
            end
        end
        return r;
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            logic [3:0] exp_out;
            exp_out = model_eval(din);
            n_checks++;
            if (dout !== exp_out) begin
                n_fail++;
                $display("FAIL %s dout din=%b actual=%b expected=%b", cur_req, din, dout, exp_out);
            end
            n_checks++;
            if (cfg_so !== m_chain[0]) begin
                n_fail++;
                $display("FAIL R7 cfg_so actual=%b expected=%b (%s)", cfg_so, m_chain[0], cur_req);
            end
        end
    end

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic set_lit(int t, int j, int comp);
        cfg_img[49-6*t-2*j-comp] = 1'b1;
    endtask

    task automatic set_or(int k, int t);
        cfg_img[19-5*k-t] = 1'b1;
    endtask

    // shift cfg_img most significant bit first, changing din while shifting
    task automatic load_cfg();
        for (int b = 49; b >= 0; b--) begin
            @(posedge clk); #2;
            cfg_shift = 1'b1;
            cfg_si = cfg_img[b];
            din = din + 3'd3;
        end
        @(posedge clk); #2;
        cfg_shift = 1'b0;
        cfg_si = 1'b0;
        @(posedge clk); #2;
    endtask

    task automatic apply(logic [2:0] v);
        din = v;
        @(negedge clk); #1;
    endtask

    initial begin
        // reset state
        cur_req = "R9";
        repeat (3) @(posedge clk);
        #2;
        check("R9 dout after reset", dout, 4'b0000);
        check("R9 cfg_so after reset", {3'b000, cfg_so}, 4'b0000);
        rst_n = 1'b1;

        // reference programming
        cur_req = "R8";
        cfg_img = '0;
        set_lit(0, 0, 0); set_lit(0, 1, 0);             // AB
        set_lit(1, 1, 1); set_lit(1, 2, 0);             // B'C
        set_lit(2, 0, 0); set_lit(2, 2, 1);             // AC'
        set_lit(3, 1, 1); set_lit(3, 2, 1);             // B'C'
        set_lit(4, 0, 0);                               // A
        set_or(0, 4); set_or(0, 3);
        set_or(1, 2); set_or(1, 0);
        set_or(2, 3); set_or(2, 0);
        set_or(3, 1); set_or(3, 4);
        load_cfg();
        check("R6 R7 cfg_so holds first streamed bit", {3'b000, cfg_so}, {3'b000, cfg_img[49]});
        cur_req = "R10";
        for (int v = 0; v < 8; v++) begin
            logic a, b, c;
            logic [3:0] e;
            a = v[2]; b = v[1]; c = v[0];
            e[0] = a | (~b & ~c);
            e[1] = (a & ~c) | (a & b);
            e[2] = (~b & ~c) | (a & b);
            e[3] = (~b & c) | a;
            apply(3'(v));
            check("R10 R4 reference equations", dout, e);
        end

        // contradictory term, empty term, empty OR rows
        cur_req = "R8";
        cfg_img = '0;
        set_lit(0, 0, 0); set_lit(0, 0, 1);             // A & A'
        set_or(0, 0);
        set_or(1, 1);                                   // term 1 empty
        set_or(2, 1); set_or(2, 0);                     // shared term 1
        load_cfg();
        cur_req = "R2";
        for (int v = 0; v < 8; v++) begin
            apply(3'(v));
            check("R2 contradictory term", {3'b000, dout[0]}, 4'b0000);
            check("R3 empty term", {3'b000, dout[1]}, 4'b0001);
            check("R4 shared term", {3'b000, dout[2]}, 4'b0001);
            check("R5 empty OR row", {3'b000, dout[3]}, 4'b0000);
        end

        // single literals routed to all outputs (R1 bit positions)
        cur_req = "R8";
        cfg_img = '0;
        set_lit(0, 0, 0);                               // A
        set_lit(1, 1, 1);                               // B'
        set_lit(2, 2, 0);                               // C
        set_lit(3, 0, 1); set_lit(3, 2, 1);             // A'C'
        set_or(0, 0); set_or(1, 1); set_or(2, 2); set_or(3, 3);
        load_cfg();
        cur_req = "R1";
        for (int v = 0; v < 8; v++) begin
            logic [3:0] e;
            e[0] = v[2];
            e[1] = ~v[1];
            e[2] = v[0];
            e[3] = ~v[2] & ~v[0];
            apply(3'(v));
            check("R1 literal positions", dout, e);
        end

        // all-zero pattern clears every output
        cur_req = "R8";
        cfg_img = '0;
        load_cfg();
        cur_req = "R5";
        for (int v = 0; v < 8; v++) begin
            apply(3'(v));
            check("R5 no OR connections", dout, 4'b0000);
        end

        // reset clears a loaded pattern
        cur_req = "R8";
        cfg_img = '0;
        set_or(0, 4); set_or(3, 4);                      // empty term 4 → 1
        load_cfg();
        apply(3'b101);
        check("R3 empty term reaches outputs", dout, 4'b1001);
        cur_req = "R9";
        rst_n = 1'b0;
        @(posedge clk); #2;
        check("R9 reset clears pattern", dout, 4'b0000);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #2;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired (%s) actual=running expected=finished", cur_req);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule